// File: doc/BRIEF.md
# Comparator Output Glitch Filter

This block sits between the raw output of an analog comparator and the logic that reacts to it. The raw bit is asynchronous to the comparator clock. It is first brought into the clock domain through a two-flop synchronizer. It is then either passed straight on (bypass) or passed through a digital filter. The filter accepts a new level only after that level has been seen on several consecutive sample ticks.

Two register fields control the filter. A 2-bit sample-mode field picks bypass or a stability count of 1, 2 or 3 samples. A 3-bit divider field sets the spacing of the sample ticks to 2^n comparator clocks. Any change to either field restarts the sample timing and the stability count but keeps the present output level. Single-cycle rise and fall pulses accompany every change of the filtered output, for use by interrupt or event logic.

Top module: `cmp_glitch_filter`

## Requirements
- R1: While rst_ni is low, and after its release until new input has propagated, filt_o, rise_o and fall_o are 0. Reset also clears the sample-tick counter.
- R2: With mode_i = 0 (bypass), filt_o after clock edge k equals the raw_i level sampled at edge k-2, whatever the value of div_i.
- R3: For div_i = n, filter sample ticks fall every 2^n clock edges. Let C be the edge at which a changed mode_i/div_i value is first sampled. The first tick is at edge C+2^n, and further ticks follow at C+2·2^n and so on.
- R4: With mode_i = N in {1,2,3}, filt_o takes a new level at the N-th consecutive sample tick whose synchronized sample differs from filt_o. The sample seen at edge E is raw_i as sampled at edge E-2.
- R5: A sample tick whose synchronized sample equals filt_o clears the count of differing samples. A pulse or glitch spanning fewer than N differing ticks never reaches filt_o.
- R6: When mode_i is non-zero and mode_i or div_i differs from its value at the previous edge, filt_o is held at that edge. At the same edge the tick spacing and the count of differing samples restart from zero.
- R7: rise_o is 1 for exactly the one cycle in which filt_o first shows 1 after 0. fall_o is 1 for exactly the one cycle in which filt_o first shows 0 after 1. The two are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Comparator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_i | input | 1 | Raw comparator output, asynchronous |
| mode_i | input | 2 | Sample mode: 0 bypass, 1..3 required consecutive samples |
| div_i | input | 3 | Sample tick spacing, 2^div_i clocks |
| filt_o | output | 1 | Filtered comparator level |
| rise_o | output | 1 | One-cycle pulse on a 0-to-1 change of filt_o |
| fall_o | output | 1 | One-cycle pulse on a 1-to-0 change of filt_o |

## Verification
The bypass property compares filt_o against raw_i sampled three edges earlier. It therefore takes for granted that raw_i never moves at a rising clock edge, even though the pin is asynchronous. It also assumes that the two control fields change only between edges, like any register output. The bench drives raw_i, mode_i, div_i and rst_ni only on falling clock edges, so each level is stable at every rising edge. The hold property expects a changed control value to be seen as a change for a single edge, which the bench respects by holding each new setting.

// File: rtl/cmpf_pkg.sv
`timescale 1ns/1ps
package cmpf_pkg;
    localparam int unsigned MODE_W = 2;
    localparam int unsigned DIV_W  = 3;
    // largest period is 2^(2^DIV_W - 1) clocks, so the count needs 2^DIV_W - 1 bits
    localparam int unsigned PRE_W  = (1 << DIV_W) - 1;

    typedef logic [MODE_W-1:0] mode_t;
    typedef logic [DIV_W-1:0]  div_t;

    typedef struct packed {
        mode_t mode;
        div_t  div;
    } cfg_t;
endpackage

// File: rtl/cmpf_sync.sv
`timescale 1ns/1ps
module cmpf_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_i;
        end else begin : g_chain
            always_comb chain_d = {chain_q[STAGES-2:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/cmpf_prescaler.sv
`timescale 1ns/1ps
module cmpf_prescaler import cmpf_pkg::*; (
    input  logic clk_i,
    input  logic rst_ni,
    input  div_t div_i,
    input  logic restart_i,
    output logic tick_o
);
    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_state_t;

    pre_state_t       st_d, st_q;
    logic [PRE_W-1:0] limit;

    always_comb begin
        // terminal count 2^div - 1 as a mask of low ones
        for (int unsigned i = 0; i < PRE_W; i++) begin
            limit[i] = (DIV_W'(i) < div_i);
        end
        tick_o = !restart_i && (st_q.cnt == limit);
        st_d   = st_q;
        if (restart_i || tick_o) st_d.cnt = '0;
        else                     st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/cmpf_stability.sv
`timescale 1ns/1ps
module cmpf_stability import cmpf_pkg::*; (
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  sample_i,
    input  logic  tick_i,
    input  logic  restart_i,
    input  mode_t mode_i,
    output logic  filt_o,
    output logic  rise_o,
    output logic  fall_o
);
    typedef struct packed {
        logic              level;
        logic              rise;
        logic              fall;
        logic [MODE_W-1:0] run;
    } stab_state_t;

    stab_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.rise = 1'b0;
        st_d.fall = 1'b0;
        if (mode_i == '0) begin
            // bypass: follow the synchronized sample every clock
            st_d.level = sample_i;
            st_d.run   = '0;
        end else if (restart_i) begin
            st_d.run = '0;
        end else if (tick_i) begin
            if (sample_i == st_q.level) begin
                st_d.run = '0;
            end else if (st_q.run + 1'b1 == mode_i) begin
                st_d.level = sample_i;
                st_d.run   = '0;
            end else begin
                st_d.run = st_q.run + 1'b1;
            end
        end
        st_d.rise = st_d.level & ~st_q.level;
        st_d.fall = ~st_d.level & st_q.level;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign filt_o = st_q.level;
    assign rise_o = st_q.rise;
    assign fall_o = st_q.fall;
endmodule

// File: rtl/cmp_glitch_filter.sv
`timescale 1ns/1ps
module cmp_glitch_filter import cmpf_pkg::*; #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              raw_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [DIV_W-1:0]  div_i,
    output logic              filt_o,
    output logic              rise_o,
    output logic              fall_o
);
    cfg_t cfg_d, cfg_q;
    logic restart;
    logic sample;
    logic tick;

    // registered copy of the control fields; any difference restarts timing
    always_comb begin
        cfg_d.mode = mode_i;
        cfg_d.div  = div_i;
        restart    = (cfg_d != cfg_q);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    cmpf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (raw_i),
        .sync_o  (sample)
    );

    cmpf_prescaler u_presc (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .div_i     (div_i),
        .restart_i (restart),
        .tick_o    (tick)
    );

    cmpf_stability u_stab (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .sample_i  (sample),
        .tick_i    (tick),
        .restart_i (restart),
        .mode_i    (mode_i),
        .filt_o    (filt_o),
        .rise_o    (rise_o),
        .fall_o    (fall_o)
    );
endmodule

// File: rtl/cmp_glitch_filter_chk.sv
`timescale 1ns/1ps
module cmp_glitch_filter_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       raw_i,
    input logic [1:0] mode_i,
    input logic [2:0] div_i,
    input logic       filt_o,
    input logic       rise_o,
    input logic       fall_o
);
    logic [1:0] age_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk_i)
        !rst_ni |=> (!filt_o && !rise_o && !fall_o));

    // R2
    a_r2_bypass_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q == 2'd3 && $past(mode_i) == 2'd0) |-> (filt_o == $past(raw_i, 3)));

    // R6
    a_r6_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i != 2'd0 && (mode_i != $past(mode_i) || div_i != $past(div_i)))
        |=> $stable(filt_o));

    // R7
    a_r7_rise_marks_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |-> (filt_o && !$past(filt_o)));

    // R7
    a_r7_fall_marks_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_o |-> (!filt_o && $past(filt_o)));

    // R7
    a_r7_rise_complete: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (filt_o && !$past(filt_o)) |-> rise_o);

    // R7
    a_r7_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rise_o && fall_o));
endmodule

bind cmp_glitch_filter cmp_glitch_filter_chk u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (raw_i),
    .mode_i (mode_i),
    .div_i  (div_i),
    .filt_o (filt_o),
    .rise_o (rise_o),
    .fall_o (fall_o)
);

// File: tb/cmp_glitch_filter_tb.sv
`timescale 1ns/1ps
module cmp_glitch_filter_tb;
    logic       clk = 1'b0;
    logic       rst_ni;
    logic       raw_i;
    logic [1:0] mode_i;
    logic [2:0] div_i;
    logic       filt_o, rise_o, fall_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    cmp_glitch_filter u_dut (
        .clk_i  (clk),
        .rst_ni (rst_ni),
        .raw_i  (raw_i),
        .mode_i (mode_i),
        .div_i  (div_i),
        .filt_o (filt_o),
        .rise_o (rise_o),
        .fall_o (fall_o)
    );

    typedef struct packed {
        logic [1:0] mode;
        logic [2:0] div;
        logic [9:0] len;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [0:NV-1] = '{
        '{2'd0, 3'd0, 10'd1},
        '{2'd0, 3'd5, 10'd1},
        '{2'd1, 3'd0, 10'd1},
        '{2'd2, 3'd0, 10'd1},
        '{2'd2, 3'd0, 10'd2},
        '{2'd3, 3'd0, 10'd2},
        '{2'd3, 3'd0, 10'd3},
        '{2'd1, 3'd2, 10'd2},
        '{2'd1, 3'd2, 10'd3},
        '{2'd2, 3'd1, 10'd3},
        '{2'd3, 3'd3, 10'd22},
        '{2'd3, 3'd3, 10'd23},
        '{2'd2, 3'd7, 10'd300}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        report();
        $finish;
    end

    int m, p, len, exp_j, first_j, rises, falls, win, n_ticks, bad;
    bit exp_hi;
    logic [8:0] pat;

    initial begin
        rst_ni = 1'b0; raw_i = 1'b0; mode_i = 2'd0; div_i = 3'd0;
        repeat (3) @(negedge clk);
        chk(filt_o == 0 && rise_o == 0 && fall_o == 0, "R1 in reset", filt_o, 0);
        rst_ni = 1'b1;
        repeat (3) @(negedge clk);
        chk(filt_o == 0 && rise_o == 0 && fall_o == 0, "R1 after release", filt_o, 0);

        // vector table: pulse of len clocks applied with a fresh setting
        for (int v = 0; v < NV; v++) begin
            m   = int'(VECS[v].mode);
            p   = 1 << VECS[v].div;
            len = int'(VECS[v].len);
            mode_i = 2'd0; div_i = 3'd0; raw_i = 1'b0;
            repeat (6) @(negedge clk);
            chk(filt_o == 0, $sformatf("R2 settle vec %0d", v), filt_o, 0);
            n_ticks = (len + 1) / p - ((p == 1) ? 1 : 0);
            exp_hi  = (m == 0) ? (len >= 1) : (n_ticks >= m);
            exp_j   = (m == 0) ? 2 : ((p == 1) ? m + 1 : m * p);
            win     = len + 4 * p * (m + 1) + 8;
            first_j = -1; rises = 0; falls = 0;
            mode_i = VECS[v].mode; div_i = VECS[v].div; raw_i = 1'b1;
            for (int j = 0; j <= win; j++) begin
                @(negedge clk);
                if (filt_o && first_j < 0) begin
                    first_j = j;
                    chk(rise_o == 1, $sformatf("R7 rise with level vec %0d", v), rise_o, 1);
                end
                rises += int'(rise_o);
                falls += int'(fall_o);
                if (j == len - 1) raw_i = 1'b0;
            end
            chk((first_j >= 0) == exp_hi, $sformatf("R4 reached output vec %0d", v),
                int'(first_j >= 0), int'(exp_hi));
            if (exp_hi)
                chk(first_j == exp_j, $sformatf("R3 latency vec %0d", v), first_j, exp_j);
            chk(rises == int'(exp_hi), $sformatf("R7 rise count vec %0d", v), rises, int'(exp_hi));
            chk(falls == int'(exp_hi), $sformatf("R7 fall count vec %0d", v), falls, int'(exp_hi));
            chk(filt_o == 0, $sformatf("R4 returns low vec %0d", v), filt_o, 0);
        end

        // R5: runs of two agreeing samples broken by one disagreeing sample, mode 3
        mode_i = 2'd0; div_i = 3'd0; raw_i = 1'b0;
        repeat (6) @(negedge clk);
        pat = 9'b011011011;
        mode_i = 2'd3; raw_i = pat[0];
        bad = 0;
        for (int j = 0; j < 20; j++) begin
            @(negedge clk);
            if (filt_o) bad++;
            raw_i = (j + 1 < 9) ? pat[j + 1] : 1'b0;
        end
        chk(bad == 0, "R5 broken runs rejected", bad, 0);
        raw_i = 1'b1;
        repeat (8) @(negedge clk);
        chk(filt_o == 1, "R4 steady level accepted", filt_o, 1);

        // R6: new setting keeps output; restart makes first tick 128 later
        mode_i = 2'd2; div_i = 3'd7; raw_i = 1'b0;
        bad = 0;
        for (int j = 0; j <= 256; j++) begin
            @(negedge clk);
            if (j == 0) chk(filt_o == 1, "R6 level held at change", filt_o, 1);
            if (j < 256 && !filt_o) bad++;
            if (j == 256) chk(filt_o == 0, "R3 fall at second tick", filt_o, 0);
        end
        chk(bad == 0, "R6 held until ticks", bad, 0);

        // R6: change of divider mid-count clears the stability count
        div_i = 3'd6; raw_i = 1'b1;
        for (int j = 0; j <= 170; j++) begin
            @(negedge clk);
            if (j == 141) chk(filt_o == 0, "R6 count cleared early", filt_o, 0);
            if (j == 164) chk(filt_o == 0, "R6 count cleared late", filt_o, 0);
            if (j == 165) chk(filt_o == 1, "R6 rise after restart", filt_o, 1);
            if (j == 100) div_i = 3'd5;
        end

        // R1: reset in the middle of operation
        rst_ni = 1'b0;
        @(negedge clk);
        chk(filt_o == 0 && rise_o == 0 && fall_o == 0, "R1 mid-run reset", filt_o, 0);
        rst_ni = 1'b1;
        @(negedge clk);
        chk(filt_o == 0, "R1 low right after release", filt_o, 0);

        report();
        $finish;
    end
endmodule